// File: doc/BRIEF.md
# Shared Serial Port Pin Controller

This block sits between eleven package pads and the serial peripherals that may use them. Seven pads can serve a synchronous serial peripheral: data in, data out, serial clock and four chip selects. Four pads serve two asynchronous serial channels, each with one transmit pad and one receive pad. Any pad that its peripheral is not using becomes a general-purpose parallel port bit. A twelfth package pin is a dedicated external clock input and never passes through this block.

Software reaches the block through a byte-wide register bus. The bus holds a 16-bit port data word and two seven-bit registers. One register hands each synchronous-serial pad either to the peripheral or to the port. The other sets whether each of those pads drives or listens. The asynchronous channel pads do not use these two registers. A transmit pad carries channel data while that channel's transmitter is enabled and otherwise drives the latched port bit. A receive pad never drives. Every pad input passes through a two-stage synchronizer before software or a peripheral sees it.

Top module: `spin_port_ctrl`

## Requirements
- R1: After reset the data, assignment and direction registers are all zero. Synchronous-serial pads 0..6 have pad_oe_o low, and transmit pads 7 and 8 drive 0 with pad_oe_o high.
- R2: Data register bits 0..7 sit at byte offset 0x15 and bit 8 sits at bit 0 of offset 0x14. On a pad 0..6 whose assignment bit is 0 and whose direction bit is 1, pad_o carries the latched data bit and pad_oe_o is high.
- R3: On a pad 0..6 whose assignment bit (offset 0x16) is 1, pad_o carries spi_do_i, and pad_oe_o is the direction bit ANDed with spi_oe_i.
- R4: On a pad 0..6 whose direction bit (offset 0x17) is 0, pad_oe_o is low whatever the assignment bit and spi_oe_i are.
- R5: Transmit pads 7 (channel 0) and 8 (channel 1) always have pad_oe_o high, whatever the assignment and direction registers hold. pad_o is uart_tx_i while that channel's uart_txe_i is high, and the latched data bit (7 or 8) otherwise.
- R6: Receive pads 9 (channel 0) and 10 (channel 1) always have pad_oe_o low. uart_rx_o is the synchronized pad level while that channel's uart_rxe_i is high, and is held at 1 (idle) otherwise.
- R7: A read of the data register returns the synchronized pad levels and not the latched write value. Offset 0x15 returns pads 7..0, and offset 0x14 returns pads 10..8 in bits 2..0 with zeros above them. A pad change reaches the read path after two clock edges.
- R8: spi_di_o carries the synchronized pad level for each pad 0..6 that is assigned to the peripheral, and 0 for each pad that is not.
- R9: The assignment and direction registers read back in bits 6..0, and bit 7 always reads 0. A read of an unmapped offset returns 0, and a write to an unmapped offset changes no register and no pad.
- R10: A write changes the pad outputs at the clock edge where wr_en_i is sampled high. A data bit written while its pad is an input appears on pad_o as soon as its direction bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| spi_do_i | input | 7 | Peripheral output level for pads 0..6 |
| spi_oe_i | input | 7 | Peripheral output enable for pads 0..6 |
| spi_di_o | output | 7 | Synchronized pad level for peripheral-owned pads |
| uart_tx_i | input | 2 | Transmit level for each channel |
| uart_txe_i | input | 2 | Transmitter enable for each channel |
| uart_rxe_i | input | 2 | Receiver enable for each channel |
| uart_rx_o | output | 2 | Synchronized receive level, 1 when receiver disabled |
| pad_i | input | 11 | Pad input levels |
| pad_o | output | 11 | Pad output levels |
| pad_oe_o | output | 11 | Pad output enables |

## Verification
The assertions check on every cycle that receive pads never drive and transmit pads always do. They also check that no synchronous-serial pad drives while its direction bit is clear, that a direction write lands on the following edge, and that an enabled receiver sees its pad exactly two edges late while a disabled one reads idle high. Only the bench scenarios show the value multiplexing: peripheral and port data on mixed assignment patterns, the separate transmit-enable switch on each channel, and reads that return pad levels rather than latched data. The same holds for the ignored unmapped writes and the write-data-then-direction ordering.

// File: rtl/spin_port_pkg.sv
package spin_port_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [ADDR_W-1:0] OFS_DATA_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_DATA_LO = 5'h15;
  localparam logic [ADDR_W-1:0] OFS_ASSIGN  = 5'h16;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 5'h17;
endpackage

// File: rtl/spin_sync.sv
module spin_sync #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spin_regs.sv
module spin_regs
  import spin_port_pkg::*;
#(
  parameter int unsigned SPI_PINS = 7,
  parameter int unsigned UART_CH  = 2,
  localparam int unsigned N_PINS  = SPI_PINS + 2 * UART_CH,
  localparam int unsigned LAT_W   = SPI_PINS + UART_CH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic [N_PINS-1:0]   pin_sync_i,
  output logic [BYTE_W-1:0]   rdata_o,
  output logic [LAT_W-1:0]    data_q_o,
  output logic [SPI_PINS-1:0] asg_q_o,
  output logic [SPI_PINS-1:0] dir_q_o
);
  logic [LAT_W-1:0]    data_q;
  logic [SPI_PINS-1:0] asg_q, dir_q;
  logic [2*BYTE_W-1:0] pin_word;

  // Data word: bits 7:0 at the low offset, bits 15:8 at the high offset.
  for (genvar b = 0; b < LAT_W; b++) begin : g_data_bit
    localparam logic [ADDR_W-1:0] OFS = (b < BYTE_W) ? OFS_DATA_LO : OFS_DATA_HI;
    localparam int unsigned       POS = b % BYTE_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    data_q[b] <= 1'b0;
      else if (wr_en_i && addr_i == OFS) data_q[b] <= wdata_i[POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asg_q <= '0;
      dir_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_ASSIGN) asg_q <= wdata_i[SPI_PINS-1:0];
      if (addr_i == OFS_DIR)    dir_q <= wdata_i[SPI_PINS-1:0];
    end
  end

  assign pin_word = (2*BYTE_W)'(pin_sync_i);

  always_comb begin
    unique case (addr_i)
      OFS_DATA_HI: rdata_o = pin_word[2*BYTE_W-1:BYTE_W];
      OFS_DATA_LO: rdata_o = pin_word[BYTE_W-1:0];
      OFS_ASSIGN:  rdata_o = BYTE_W'(asg_q);
      OFS_DIR:     rdata_o = BYTE_W'(dir_q);
      default:     rdata_o = '0;
    endcase
  end

  assign data_q_o = data_q;
  assign asg_q_o  = asg_q;
  assign dir_q_o  = dir_q;
endmodule

// File: rtl/spin_pad_mux.sv
module spin_pad_mux #(
  parameter int unsigned SPI_PINS = 7,
  parameter int unsigned UART_CH  = 2,
  localparam int unsigned N_PINS  = SPI_PINS + 2 * UART_CH,
  localparam int unsigned LAT_W   = SPI_PINS + UART_CH,
  localparam int unsigned TX_BASE = SPI_PINS,
  localparam int unsigned RX_BASE = SPI_PINS + UART_CH
) (
  input  logic [LAT_W-1:0]    data_q_i,
  input  logic [SPI_PINS-1:0] asg_q_i,
  input  logic [SPI_PINS-1:0] dir_q_i,
  input  logic [N_PINS-1:0]   pin_sync_i,
  input  logic [SPI_PINS-1:0] spi_do_i,
  input  logic [SPI_PINS-1:0] spi_oe_i,
  output logic [SPI_PINS-1:0] spi_di_o,
  input  logic [UART_CH-1:0]  uart_tx_i,
  input  logic [UART_CH-1:0]  uart_txe_i,
  input  logic [UART_CH-1:0]  uart_rxe_i,
  output logic [UART_CH-1:0]  uart_rx_o,
  output logic [N_PINS-1:0]   pad_o,
  output logic [N_PINS-1:0]   pad_oe_o
);
  for (genvar p = 0; p < SPI_PINS; p++) begin : g_spi_pin
    // Direction register gates both port and peripheral drive.
    assign pad_o[p]    = asg_q_i[p] ? spi_do_i[p] : data_q_i[p];
    assign pad_oe_o[p] = dir_q_i[p] & (asg_q_i[p] ? spi_oe_i[p] : 1'b1);
    assign spi_di_o[p] = asg_q_i[p] & pin_sync_i[p];
  end

  for (genvar c = 0; c < UART_CH; c++) begin : g_uart_ch
    assign pad_o[TX_BASE+c]    = uart_txe_i[c] ? uart_tx_i[c] : data_q_i[TX_BASE+c];
    assign pad_oe_o[TX_BASE+c] = 1'b1;
    assign pad_o[RX_BASE+c]    = 1'b0;
    assign pad_oe_o[RX_BASE+c] = 1'b0;
    // Disabled receiver sees line idle.
    assign uart_rx_o[c]        = uart_rxe_i[c] ? pin_sync_i[RX_BASE+c] : 1'b1;
  end
endmodule

// File: rtl/spin_port_ctrl.sv
module spin_port_ctrl
  import spin_port_pkg::*;
#(
  parameter int unsigned SPI_PINS    = 7,
  parameter int unsigned UART_CH     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned N_PINS     = SPI_PINS + 2 * UART_CH,
  localparam int unsigned LAT_W      = SPI_PINS + UART_CH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  input  logic [SPI_PINS-1:0] spi_do_i,
  input  logic [SPI_PINS-1:0] spi_oe_i,
  output logic [SPI_PINS-1:0] spi_di_o,
  input  logic [UART_CH-1:0]  uart_tx_i,
  input  logic [UART_CH-1:0]  uart_txe_i,
  input  logic [UART_CH-1:0]  uart_rxe_i,
  output logic [UART_CH-1:0]  uart_rx_o,
  input  logic [N_PINS-1:0]   pad_i,
  output logic [N_PINS-1:0]   pad_o,
  output logic [N_PINS-1:0]   pad_oe_o
);
  logic [N_PINS-1:0]   pin_sync;
  logic [LAT_W-1:0]    data_q;
  logic [SPI_PINS-1:0] asg_q, dir_q;

  spin_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pin_sync)
  );

  spin_regs #(.SPI_PINS(SPI_PINS), .UART_CH(UART_CH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .rdata_o   (rdata_o),
    .data_q_o  (data_q),
    .asg_q_o   (asg_q),
    .dir_q_o   (dir_q)
  );

  spin_pad_mux #(.SPI_PINS(SPI_PINS), .UART_CH(UART_CH)) u_mux (
    .data_q_i  (data_q),
    .asg_q_i   (asg_q),
    .dir_q_i   (dir_q),
    .pin_sync_i(pin_sync),
    .spi_do_i  (spi_do_i),
    .spi_oe_i  (spi_oe_i),
    .spi_di_o  (spi_di_o),
    .uart_tx_i (uart_tx_i),
    .uart_txe_i(uart_txe_i),
    .uart_rxe_i(uart_rxe_i),
    .uart_rx_o (uart_rx_o),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o)
  );
endmodule

// File: rtl/spin_port_chk.sv
module spin_port_chk
  import spin_port_pkg::*;
#(
  parameter int unsigned SPI_PINS = 7,
  parameter int unsigned UART_CH  = 2,
  localparam int unsigned N_PINS  = SPI_PINS + 2 * UART_CH,
  localparam int unsigned TX_BASE = SPI_PINS,
  localparam int unsigned RX_BASE = SPI_PINS + UART_CH
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [BYTE_W-1:0]   wdata_i,
  input logic [UART_CH-1:0]  uart_rxe_i,
  input logic [UART_CH-1:0]  uart_rx_o,
  input logic [N_PINS-1:0]   pad_i,
  input logic [N_PINS-1:0]   pad_oe_o,
  input logic [SPI_PINS-1:0] dir_q_i
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_tx_always_drives_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o[TX_BASE +: UART_CH] == '1);

  p_rx_never_drives_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o[RX_BASE +: UART_CH] == '0);

  p_oe_needs_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o[SPI_PINS-1:0] & ~dir_q_i) == '0);

  p_dir_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && $past(wr_en_i && addr_i == OFS_DIR))
      |-> dir_q_i == $past(wdata_i[SPI_PINS-1:0]));

  p_rx_idle_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uart_rxe_i[0] |-> uart_rx_o[0]);

  p_rx_two_stage_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && uart_rxe_i[0]) |-> uart_rx_o[0] == $past(pad_i[RX_BASE], 2));
endmodule

bind spin_port_ctrl spin_port_chk #(.SPI_PINS(SPI_PINS), .UART_CH(UART_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .uart_rxe_i(uart_rxe_i),
  .uart_rx_o (uart_rx_o),
  .pad_i     (pad_i),
  .pad_oe_o  (pad_oe_o),
  .dir_q_i   (dir_q)
);

// File: tb/spin_port_ctrl_tb.sv
module spin_port_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [6:0]  spi_do_i = '0, spi_oe_i = '0, spi_di_o;
  logic [1:0]  uart_tx_i = '0, uart_txe_i = '0, uart_rxe_i = '0, uart_rx_o;
  logic [10:0] pad_i = '0, pad_o, pad_oe_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  spin_port_ctrl u_dut (.*);

  typedef struct packed {
    logic [6:0] asg, dir;
    logic [7:0] dat;
    logic [6:0] sdo, soe, exp_o, exp_oe;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{7'h00, 7'h7F, 8'h55, 7'h2A, 7'h7F, 7'h55, 7'h7F},
    '{7'h7F, 7'h7F, 8'h55, 7'h2A, 7'h7F, 7'h2A, 7'h7F},
    '{7'h0F, 7'h3C, 8'h00, 7'h7F, 7'h00, 7'h0F, 7'h30},
    '{7'h70, 7'h00, 8'h7F, 7'h00, 7'h7F, 7'h0F, 7'h00},
    '{7'h33, 7'h5A, 8'h12, 7'h61, 7'h48, 7'h21, 7'h48}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
    #1;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 oe", 16'(pad_oe_o), 16'h180);
    chk("R1 pad", 16'(pad_o), 16'h000);
    rd(5'h16, r); chk("R1 assign", 16'(r), 16'h00);
    rd(5'h17, r); chk("R1 dir", 16'(r), 16'h00);

    // Vector table: R2 R3 R4 R8
    pad_i[6:0] = 7'h7F;
    foreach (VECS[i]) begin
      wr(5'h16, 8'(VECS[i].asg));
      wr(5'h17, 8'(VECS[i].dir));
      wr(5'h15, VECS[i].dat);
      spi_do_i = VECS[i].sdo;
      spi_oe_i = VECS[i].soe;
      idle(2);
      chk("R2/R3 pad_o", 16'(pad_o[6:0]), 16'(VECS[i].exp_o));
      chk("R3/R4 pad_oe", 16'(pad_oe_o[6:0]), 16'(VECS[i].exp_oe));
      chk("R8 spi_di", 16'(spi_di_o), 16'(VECS[i].asg));
    end

    // R9 readback and unmapped offsets
    wr(5'h16, 8'hFF);
    rd(5'h16, r); chk("R9 assign bit7", 16'(r), 16'h7F);
    wr(5'h17, 8'h00);
    wr(5'h10, 8'hFF);
    rd(5'h10, r); chk("R9 unmapped read", 16'(r), 16'h00);
    rd(5'h17, r); chk("R9 unmapped write dir", 16'(r), 16'h00);
    chk("R9 unmapped write oe", 16'(pad_oe_o), 16'h180);

    // R5 transmit pads
    wr(5'h17, 8'h7F);
    wr(5'h15, 8'h80);
    wr(5'h14, 8'h01);
    chk("R5 tx latched", 16'(pad_o[8:7]), 16'h3);
    chk("R5 tx oe", 16'(pad_oe_o[8:7]), 16'h3);
    uart_txe_i = 2'b01; uart_tx_i = 2'b00; #1;
    chk("R5 tx uart ch0", 16'(pad_o[8:7]), 16'h2);
    uart_txe_i = 2'b11; uart_tx_i = 2'b01; #1;
    chk("R5 tx uart both", 16'(pad_o[8:7]), 16'h1);
    uart_txe_i = 2'b00; #1;

    // R6 receive pads
    wr(5'h17, 8'hFF);
    pad_i[10:8] = 3'b101;
    idle(3);
    chk("R6 rx idle", 16'(uart_rx_o), 16'h3);
    chk("R6 rx oe", 16'(pad_oe_o[10:9]), 16'h0);
    uart_rxe_i = 2'b01; #1;
    chk("R6 rx enabled", 16'(uart_rx_o), 16'h2);
    rd(5'h14, r); chk("R7 high byte", 16'(r), 16'h05);

    // R7 read returns pad, two-edge latency
    wr(5'h17, 8'h00);
    wr(5'h16, 8'h00);
    wr(5'h15, 8'h01);
    pad_i[7:0] = 8'h00;
    idle(3);
    rd(5'h15, r); chk("R7 pad not latch", 16'(r), 16'h00);
    @(negedge clk_i); pad_i[0] = 1'b1;
    @(negedge clk_i); rd(5'h15, r); chk("R7 one edge", 16'(r), 16'h00);
    @(negedge clk_i); rd(5'h15, r); chk("R7 two edges", 16'(r), 16'h01);

    // R10 data before direction
    wr(5'h15, 8'h04);
    chk("R10 input oe", 16'(pad_oe_o[2]), 16'h0);
    chk("R10 latched level", 16'(pad_o[2]), 16'h1);
    wr(5'h17, 8'h04);
    chk("R10 dir oe", 16'(pad_oe_o[2]), 16'h1);
    chk("R10 dir level", 16'(pad_o[2]), 16'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule